// File: doc/BRIEF.md
# Timer Trigger Output Generator

This block turns the event strobes of a free-running timer into a single output waveform. Every clock it samples a one-cycle overflow strobe and a one-cycle compare-match strobe. It also samples a run/stop level and a small set of control fields. From these it drives a registered PWM/trigger pin.

A two-bit event selector picks which strobes act on the pin. Overflow can act alone, or overflow and match can act together. A compare-enable bit gates the match strobe. A pulse/toggle bit sets what a selected event does: it either produces a one-cycle pulse or flips the pin.

A polarity bit sets the level the pin rests at and the direction of pulses. While the timer is stopped, or while no trigger source is selected, the pin is held at that polarity level. A second pin is a plain general-purpose output that follows one control bit. Both pins are registered. A value sampled at one rising edge appears on the pins just after that edge.

Top module: `tmr_trig_out`

## Requirements
- R1: While rst_n is low, pwm_out and gpo_out are both 0.
- R2: With trig_mode equal to 2'b00 or to 2'b11, pwm_out is set to the polarity value sampled at the previous edge, whatever the event strobes are.
- R3: With trig_mode equal to 2'b01, only ovf_evt acts on pwm_out, and match_evt has no effect.
- R4: With trig_mode equal to 2'b10, ovf_evt acts on pwm_out. match_evt also acts, but only while cmp_en is 1.
- R5: With toggle_sel equal to 0 (pulse mode) and the timer running, a selected event sampled at an edge drives pwm_out to the inverse of polarity for exactly the following cycle. In every other running cycle, pwm_out equals polarity.
- R6: With toggle_sel equal to 1 (toggle mode) and the timer running, each edge that samples a selected event inverts pwm_out. Edges without a selected event leave pwm_out unchanged.
- R7: In toggle mode, if an overflow and a selected match are sampled at the same edge, pwm_out inverts once, not twice.
- R8: While run is 0, pwm_out is set to the sampled polarity value and all event strobes are ignored.
- R9: With polarity 0, the pin rests low and pulses are high. With polarity 1, the pin rests high and pulses are low.
- R10: gpo_out takes the value of gpo_bit sampled at the previous edge, independent of every other input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | 1 while the timer counts, 0 while it is stopped |
| ovf_evt | input | 1 | One-cycle timer overflow strobe |
| match_evt | input | 1 | One-cycle compare-match strobe |
| trig_mode | input | 2 | Event selection: 00 none, 01 overflow, 10 overflow and match, 11 none |
| toggle_sel | input | 1 | 0 selects pulse mode, 1 selects toggle mode |
| polarity | input | 1 | Rest level of the pin; pulses go to its inverse |
| cmp_en | input | 1 | 1 allows match_evt to act when trig_mode is 10 |
| gpo_bit | input | 1 | Value to be driven on gpo_out |
| pwm_out | output | 1 | Registered PWM/trigger pin |
| gpo_out | output | 1 | Registered general-purpose output pin |

## Verification
Overflow and compare-match strobes can land on the same edge. When they do, the pin must react once: a single one-cycle pulse in pulse mode, or a single inversion in toggle mode. The bench raises both strobes together in both modes, with cmp_en set and cleared. A reference model computes the expected pin level from the sampled inputs every cycle, and the bench compares against it. A double toggle would leave the pin unchanged, and that shows up at once as a mismatch.

// File: rtl/tmr_trig_out_pkg.sv
package tmr_trig_out_pkg;

    localparam int unsigned MODE_W = 2;

    typedef enum logic [MODE_W-1:0] {
        TRIG_OFF       = 2'b00,
        TRIG_OVF       = 2'b01,
        TRIG_OVF_MATCH = 2'b10,
        TRIG_RSVD      = 2'b11
    } trig_mode_e;

    typedef struct packed {
        logic pwm;
        logic gpo;
    } pin_state_t;

    localparam pin_state_t PIN_RESET = '{pwm: 1'b0, gpo: 1'b0};

endpackage

// File: rtl/tmr_trig_evt_sel.sv
module tmr_trig_evt_sel
    import tmr_trig_out_pkg::*;
(
    input  logic       run,
    input  trig_mode_e mode,
    input  logic       cmp_en,
    input  logic       ovf_evt,
    input  logic       match_evt,
    output logic       fire,
    output logic       force_idle
);

    logic src_active;
    logic match_ok;

    always_comb begin
        src_active = 1'b0;
        match_ok   = 1'b0;
        unique case (mode)
            TRIG_OVF:       src_active = 1'b1;
            TRIG_OVF_MATCH: begin
                src_active = 1'b1;
                match_ok   = cmp_en;
            end
            default:        src_active = 1'b0;
        endcase
        force_idle = !run || !src_active;
        // One combined strobe: coincident events collapse to one action.
        fire       = !force_idle && (ovf_evt || (match_ok && match_evt));
    end

endmodule

// File: rtl/tmr_trig_pin_ctrl.sv
module tmr_trig_pin_ctrl
    import tmr_trig_out_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    input  logic force_idle,
    input  logic toggle_sel,
    input  logic polarity,
    input  logic gpo_bit,
    output logic pwm,
    output logic gpo
);

    pin_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.gpo = gpo_bit;
        if (force_idle) begin
            st_d.pwm = polarity;
        end else if (toggle_sel) begin
            st_d.pwm = fire ? !st_q.pwm : st_q.pwm;
        end else begin
            st_d.pwm = fire ? !polarity : polarity;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= PIN_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign pwm = st_q.pwm;
    assign gpo = st_q.gpo;

endmodule

// File: rtl/tmr_trig_out.sv
module tmr_trig_out
    import tmr_trig_out_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              ovf_evt,
    input  logic              match_evt,
    input  logic [MODE_W-1:0] trig_mode,
    input  logic              toggle_sel,
    input  logic              polarity,
    input  logic              cmp_en,
    input  logic              gpo_bit,
    output logic              pwm_out,
    output logic              gpo_out
);

    logic fire;
    logic force_idle;

    tmr_trig_evt_sel u_sel (
        .run        (run),
        .mode       (trig_mode_e'(trig_mode)),
        .cmp_en     (cmp_en),
        .ovf_evt    (ovf_evt),
        .match_evt  (match_evt),
        .fire       (fire),
        .force_idle (force_idle)
    );

    tmr_trig_pin_ctrl u_pin (
        .clk        (clk),
        .rst_n      (rst_n),
        .fire       (fire),
        .force_idle (force_idle),
        .toggle_sel (toggle_sel),
        .polarity   (polarity),
        .gpo_bit    (gpo_bit),
        .pwm        (pwm_out),
        .gpo        (gpo_out)
    );

endmodule

// File: rtl/tmr_trig_out_chk.sv
module tmr_trig_out_chk
    import tmr_trig_out_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              run,
    input logic              ovf_evt,
    input logic              match_evt,
    input logic [MODE_W-1:0] trig_mode,
    input logic              toggle_sel,
    input logic              polarity,
    input logic              cmp_en,
    input logic              gpo_bit,
    input logic              pwm_out,
    input logic              gpo_out
);

    // R1
    a_r1_reset_low: assert property (@(posedge clk)
        !rst_n |=> (!pwm_out && !gpo_out));

    // R2
    a_r2_idle_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_mode == 2'b00 || trig_mode == 2'b11) |=> (pwm_out == $past(polarity)));

    // R8
    a_r8_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (pwm_out == $past(polarity)));

    // R5
    a_r5_pulse_level: assert property (@(posedge clk) disable iff (!rst_n)
        (run && trig_mode == 2'b01 && !toggle_sel && ovf_evt) |=> (pwm_out != $past(polarity)));

    // R6
    a_r6_toggle_flip: assert property (@(posedge clk) disable iff (!rst_n)
        (run && trig_mode == 2'b01 && toggle_sel && ovf_evt) |=> (pwm_out != $past(pwm_out)));

    // R3
    a_r3_match_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (run && trig_mode == 2'b01 && toggle_sel && !ovf_evt) |=> $stable(pwm_out));

    // R4
    a_r4_match_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (run && trig_mode == 2'b10 && toggle_sel && !ovf_evt && !cmp_en) |=> $stable(pwm_out));

    // R7
    a_r7_single_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        (run && trig_mode == 2'b10 && toggle_sel && cmp_en && ovf_evt && match_evt)
        |=> (pwm_out != $past(pwm_out)));

    // R10
    a_r10_gpo_follow: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (gpo_out == $past(gpo_bit)));

endmodule

bind tmr_trig_out tmr_trig_out_chk u_chk (.*);

// File: tb/tmr_trig_out_tb_top.sv
module tmr_trig_out_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       run = 1'b0;
    logic       ovf_evt = 1'b0;
    logic       match_evt = 1'b0;
    logic [1:0] trig_mode = 2'b00;
    logic       toggle_sel = 1'b0;
    logic       polarity = 1'b0;
    logic       cmp_en = 1'b0;
    logic       gpo_bit = 1'b0;
    logic       pwm_out;
    logic       gpo_out;

    int n_cmp = 0;
    int n_bad = 0;
    string tag = "R1";
    logic exp_pwm = 1'b0;
    logic exp_gpo = 1'b0;
    logic stim_done = 1'b0;

    always #2 clk = !clk;

    tmr_trig_out dut_i (
        .clk(clk), .rst_n(rst_n), .run(run), .ovf_evt(ovf_evt),
        .match_evt(match_evt), .trig_mode(trig_mode), .toggle_sel(toggle_sel),
        .polarity(polarity), .cmp_en(cmp_en), .gpo_bit(gpo_bit),
        .pwm_out(pwm_out), .gpo_out(gpo_out)
    );

    // Behavioural reference: decide how many actions this edge carries.
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            exp_pwm <= 1'b0;
            exp_gpo <= 1'b0;
        end else begin
            int actions;
            bit running_src;
            actions = 0;
            running_src = run && (trig_mode == 2'd1 || trig_mode == 2'd2);
            if (running_src) begin
                if (ovf_evt) actions = actions + 1;
                if (trig_mode == 2'd2 && cmp_en && match_evt) actions = actions + 1;
                if (actions > 1) actions = 1;   // R7: coincident events count once
            end
            if (!running_src)         exp_pwm <= polarity;
            else if (toggle_sel)      exp_pwm <= (actions == 1) ? ~exp_pwm : exp_pwm;
            else                      exp_pwm <= (actions == 1) ? ~polarity : polarity;
            exp_gpo <= gpo_bit;
        end
    end

    always @(negedge clk) begin
        n_cmp = n_cmp + 1;
        if (pwm_out !== exp_pwm) begin
            n_bad = n_bad + 1;
            $display("FAIL %s pwm_out actual=%b expected=%b at %0t", tag, pwm_out, exp_pwm, $time);
        end
        n_cmp = n_cmp + 1;
        if (gpo_out !== exp_gpo) begin
            n_bad = n_bad + 1;
            $display("FAIL R10 gpo_out actual=%b expected=%b at %0t", gpo_out, exp_gpo, $time);
        end
    end

    task automatic step(input logic o, input logic m);
        ovf_evt   = o;
        match_evt = m;
        @(posedge clk);
        #1;
        ovf_evt   = 1'b0;
        match_evt = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0);
    endtask

    initial begin
        #(4 * 200000);
        n_bad = n_bad + 1;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        tag = "R1";
        gpo_bit = 1'b1;
        polarity = 1'b1;
        idle(3);
        #1; rst_n = 1'b1;
        // R2: modes 00 and 11 hold the polarity level
        tag = "R2"; run = 1'b1;
        trig_mode = 2'b00; step(1, 1); step(1, 0); polarity = 1'b0; step(1, 1); idle(2);
        trig_mode = 2'b11; toggle_sel = 1'b1; step(1, 1); polarity = 1'b1; step(1, 0); idle(2);
        // R3 R5: overflow pulses in mode 01, matches ignored
        tag = "R3 R5"; run = 1'b0; polarity = 1'b0; toggle_sel = 1'b0; idle(1);
        run = 1'b1; trig_mode = 2'b01; cmp_en = 1'b1; gpo_bit = 1'b0;
        step(1, 0); idle(2); step(0, 1); idle(2); step(1, 0); step(1, 0); idle(1);
        // R4: match acts only with compare enabled
        tag = "R4"; trig_mode = 2'b10;
        step(0, 1); idle(2); cmp_en = 1'b0; step(0, 1); idle(2); step(1, 0); idle(1);
        // R6: toggling
        tag = "R6"; toggle_sel = 1'b1; trig_mode = 2'b01;
        step(1, 0); idle(2); step(1, 0); step(0, 1); step(1, 0); idle(2);
        // R7: coincident events in both modes
        tag = "R7"; trig_mode = 2'b10; cmp_en = 1'b1;
        step(1, 1); idle(1); step(1, 1); step(1, 1); idle(1);
        cmp_en = 1'b0; step(1, 1); idle(1);
        toggle_sel = 1'b0; cmp_en = 1'b1; step(1, 1); idle(2);
        // R9: negative pulses with polarity 1
        tag = "R9"; run = 1'b0; polarity = 1'b1; idle(2);
        run = 1'b1; step(1, 0); idle(2); step(0, 1); idle(2);
        // R8: stopped timer ignores events
        tag = "R8"; run = 1'b0; toggle_sel = 1'b1; step(1, 1); step(1, 0);
        polarity = 1'b0; step(0, 1); idle(2);
        // mixed traffic
        tag = "R4 R5 R6 R7 R8 R9 R10";
        for (int i = 0; i < 3000; i++) begin
            run = ($urandom_range(0, 7) != 0);
            if ($urandom_range(0, 15) == 0) trig_mode = 2'($urandom_range(0, 3));
            if ($urandom_range(0, 15) == 0) toggle_sel = 1'($urandom_range(0, 1));
            if (!run && $urandom_range(0, 3) == 0) polarity = 1'($urandom_range(0, 1));
            cmp_en = 1'($urandom_range(0, 1));
            gpo_bit = 1'($urandom_range(0, 1));
            step(1'($urandom_range(0, 3) == 0), 1'($urandom_range(0, 3) == 0));
        end
        // R1: reset mid-run clears both pins
        tag = "R1"; gpo_bit = 1'b1; polarity = 1'b1; run = 1'b0; idle(2);
        rst_n = 1'b0; #2;
        n_cmp = n_cmp + 1;
        if (pwm_out !== 1'b0 || gpo_out !== 1'b0) begin
            n_bad = n_bad + 1;
            $display("FAIL R1 pins actual=%b%b expected=00", pwm_out, gpo_out);
        end
        idle(2);
        stim_done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule